// File: doc/BRIEF.md
# Peripheral Service-Cycle Sequencer

This block is the state machine that a peripheral controller uses to get service from a shared byte-wide I/O-processor bus. The controller's own logic asks for service by naming a function (data in, data out, order in or order out) and, for data, how many bytes it wants to move. The sequencer then raises the shared service call. It waits for a grant from the acknowledge strobe while the daisy-chained priority input is high. It answers the grant by putting its device address on the response lines together with an acknowledge.

Once connected, the sequencer issues request strobes one subcycle at a time. The function code appears on the two request-code lines during the first strobe only. The sequencer raises its end-data flag on the last byte it wants to move. When the processor closes each strobe, the sequencer samples end-data, which is its own flag ORed with the processor's, and end-service. From these it decides to request another byte, to take one terminal-order subcycle, or to drop off the bus. While the unit is calling, the priority chain is blocked toward lower-priority units.

Top module: `svc_seq_top`

## Requirements
- R1: After reset every output is low except `prioOut`, which follows `prioIn`.
- R2: `callOut` rises in the cycle after `svcWant` is seen while idle. It stays high until a grant is taken and is low at all other times.
- R3: `prioOut` equals `prioIn` while the unit is not calling and is low while `callOut` is high.
- R4: A grant is taken only in a cycle where `callOut`, `ascIn` and `prioIn` are all high. In the next cycle `rspAck` is high for exactly one cycle with `rspAddr` equal to the DEV_ADDR parameter. At all other times `rspAck` is low and `rspAddr` is zero.
- R5: The first request strobe starts in the cycle after `rspAck`. A raised `reqStrobe` stays high until a cycle in which `stbDone` is high.
- R6: On the first strobe of a service cycle, `dorOut` and `iorOut` carry the function code. `dorOut` is bit 1 and `iorOut` is bit 0: 00 is data in, 01 is data out, 10 is order in, 11 is order out. On every later strobe both lines are zero.
- R7: In a data cycle, `edOut` is high on the byte whose zero-based index equals `svcLen`, so a data cycle moves `svcLen`+1 bytes (one to four). In an order cycle, `edOut` is high on the single byte.
- R8: `edOut` is never high during a terminal-order subcycle, and `termPhase` is high exactly during such subcycles.
- R9: When `stbDone` is high during a data or order subcycle, the sequencer acts in the next cycle as follows. If `esIn` is high, it disconnects (all strobes low, idle). If `esIn` is low and both `edOut` and `edIn` are low, it issues another data strobe. If `esIn` is low and either `edOut` or `edIn` is high, it issues one terminal-order strobe.
- R10: A terminal-order subcycle that ends with `esIn` high disconnects. One that ends with `esIn` low is followed by another terminal-order strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| svcWant | input | 1 | Local request to start a service cycle, seen while idle |
| svcKind | input | 2 | Function code for the requested cycle |
| svcLen | input | LEN_W | Data bytes minus one for a data cycle |
| callOut | output | 1 | Shared service call |
| ascIn | input | 1 | Acknowledge-service-call strobe from the processor |
| prioIn | input | 1 | Priority from the higher-priority neighbour |
| prioOut | output | 1 | Priority passed to the lower-priority neighbour |
| rspAck | output | 1 | Acknowledge driven with the device address |
| rspAddr | output | ADDR_W | Device address on the response lines, zero when off the bus |
| reqStrobe | output | 1 | Request strobe for the current subcycle |
| dorOut | output | 1 | Request-code high bit |
| iorOut | output | 1 | Request-code low bit |
| stbDone | input | 1 | Processor closes the current strobe (trailing edge) |
| edIn | input | 1 | End-data from the processor |
| esIn | input | 1 | End-service from the processor |
| edOut | output | 1 | End-data from this controller |
| termPhase | output | 1 | Current subcycle is a terminal order |

## Verification
A wrong internal state shows at the strobe and response ports within one cycle. A byte counter that is off by one moves `edOut` to the wrong strobe, so the terminal subcycle arrives early or late on the same service cycle. A stale first-strobe flag leaves a nonzero request code on a later strobe. A wrong decision state shows up as a strobe after `esIn`, or as a missing strobe, in the cycle after `stbDone`. Random function codes, lengths and end-flag patterns are mixed with directed full-length and single-byte cycles. A grant attempt with priority held low checks that the call line and priority chain are correct before any connect.

// File: rtl/svc_seq_pkg.sv
package svc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALL,
    ST_CONN,
    ST_XFER,
    ST_TERM
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new request
    logic stepByte;   // a subcycle has ended
    logic driveAddr;  // put device address on response lines
    logic dataPhase;  // data or order subcycle active
    logic termPhase;  // terminal-order subcycle active
  } seqCtl_t;

endpackage

// File: rtl/svc_seq_dp.sv
module svc_seq_dp
  import svc_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA5,
  localparam int LEN_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [1:0]        svcKind,
  input  logic [LEN_W-1:0]  svcLen,
  output logic              lastByte,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [1:0]        fnCode,
  output logic              edOut
);

  localparam logic [LEN_W-1:0] CNT_TOP = LEN_W'(MAX_BYTES - 1);

  logic [1:0]       kindQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] cntQ;
  logic             firstQ;
  logic             isOrder;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ  <= '0;
      lenQ   <= '0;
      cntQ   <= '0;
      firstQ <= 1'b0;
    end else if (ctl.load) begin
      kindQ  <= svcKind;
      lenQ   <= svcLen;
      cntQ   <= '0;
      firstQ <= 1'b1;
    end else if (ctl.stepByte) begin
      firstQ <= 1'b0;
      if (ctl.dataPhase && cntQ != CNT_TOP)
        cntQ <= cntQ + 1'b1;
    end
  end

  // order cycles carry one byte; a data cycle ends at its length or at the cap
  assign isOrder  = kindQ[1];
  assign lastByte = isOrder || (cntQ == lenQ) || (cntQ == CNT_TOP);

  assign rspAddr = ctl.driveAddr ? DEV_ADDR : '0;
  assign fnCode  = (ctl.dataPhase && firstQ) ? kindQ : 2'b00;
  assign edOut   = ctl.dataPhase && lastByte;

endmodule

// File: rtl/svc_seq_ctrl.sv
module svc_seq_ctrl
  import svc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    svcWant,
  input  logic    ascIn,
  input  logic    prioIn,
  input  logic    stbDone,
  input  logic    edIn,
  input  logic    esIn,
  input  logic    lastByte,
  output seqCtl_t ctl,
  output logic    callOut,
  output logic    rspAck,
  output logic    reqStrobe
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    ctl       = '0;
    callOut   = 1'b0;
    rspAck    = 1'b0;
    reqStrobe = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (svcWant) begin
          ctl.load = 1'b1;
          stateD   = ST_CALL;
        end
      end
      ST_CALL: begin
        callOut = 1'b1;
        if (ascIn && prioIn) stateD = ST_CONN;
      end
      ST_CONN: begin
        ctl.driveAddr = 1'b1;
        rspAck        = 1'b1;
        stateD        = ST_XFER;
      end
      ST_XFER: begin
        ctl.dataPhase = 1'b1;
        reqStrobe     = 1'b1;
        if (stbDone) begin
          ctl.stepByte = 1'b1;
          if (esIn)                  stateD = ST_IDLE;
          else if (lastByte || edIn) stateD = ST_TERM;
        end
      end
      ST_TERM: begin
        ctl.termPhase = 1'b1;
        reqStrobe     = 1'b1;
        if (stbDone) begin
          ctl.stepByte = 1'b1;
          if (esIn) stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/svc_seq_top.sv
module svc_seq_top
  import svc_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'hA5,
  localparam int LEN_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              svcWant,
  input  logic [1:0]        svcKind,
  input  logic [LEN_W-1:0]  svcLen,
  output logic              callOut,
  input  logic              ascIn,
  input  logic              prioIn,
  output logic              prioOut,
  output logic              rspAck,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              reqStrobe,
  output logic              dorOut,
  output logic              iorOut,
  input  logic              stbDone,
  input  logic              edIn,
  input  logic              esIn,
  output logic              edOut,
  output logic              termPhase
);

  seqCtl_t    ctl;
  logic       lastByte;
  logic [1:0] fnCode;

  svc_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .svcWant   (svcWant),
    .ascIn     (ascIn),
    .prioIn    (prioIn),
    .stbDone   (stbDone),
    .edIn      (edIn),
    .esIn      (esIn),
    .lastByte  (lastByte),
    .ctl       (ctl),
    .callOut   (callOut),
    .rspAck    (rspAck),
    .reqStrobe (reqStrobe)
  );

  svc_seq_dp #(
    .ADDR_W    (ADDR_W),
    .MAX_BYTES (MAX_BYTES),
    .DEV_ADDR  (DEV_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .svcKind  (svcKind),
    .svcLen   (svcLen),
    .lastByte (lastByte),
    .rspAddr  (rspAddr),
    .fnCode   (fnCode),
    .edOut    (edOut)
  );

  // a calling unit blocks the chain below it
  assign prioOut   = prioIn && !callOut;
  assign dorOut    = fnCode[1];
  assign iorOut    = fnCode[0];
  assign termPhase = ctl.termPhase;

endmodule

// File: rtl/svc_seq_chk.sv
module svc_seq_chk (
  input logic clk,
  input logic rstN,
  input logic callOut,
  input logic ascIn,
  input logic prioIn,
  input logic prioOut,
  input logic rspAck,
  input logic reqStrobe,
  input logic dorOut,
  input logic iorOut,
  input logic stbDone,
  input logic esIn,
  input logic edOut,
  input logic termPhase
);

  assert_chain_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    callOut |-> !prioOut);

  assert_grant_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspAck |-> $past(callOut && ascIn && prioIn));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspAck |=> !rspAck);

  assert_first_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspAck |=> reqStrobe);

  assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && !stbDone) |=> reqStrobe);

  assert_code_in_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dorOut || iorOut) |-> (reqStrobe && !termPhase));

  assert_no_ed_in_term_R8: assert property (@(posedge clk) disable iff (!rstN)
    termPhase |-> !edOut);

  assert_es_disconnect_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && stbDone && esIn) |=> !reqStrobe);

  assert_term_stays_R10: assert property (@(posedge clk) disable iff (!rstN)
    (termPhase && stbDone && !esIn) |=> termPhase);

endmodule

bind svc_seq_top svc_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .callOut   (callOut),
  .ascIn     (ascIn),
  .prioIn    (prioIn),
  .prioOut   (prioOut),
  .rspAck    (rspAck),
  .reqStrobe (reqStrobe),
  .dorOut    (dorOut),
  .iorOut    (iorOut),
  .stbDone   (stbDone),
  .esIn      (esIn),
  .edOut     (edOut),
  .termPhase (termPhase)
);

// File: tb/svc_seq_top_tb.sv
module svc_seq_top_tb;

  localparam logic [7:0] ADDR = 8'hA5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       svcWant = 1'b0;
  logic [1:0] svcKind = 2'b00;
  logic [1:0] svcLen = 2'b00;
  logic       callOut, prioOut, rspAck, reqStrobe, dorOut, iorOut, edOut, termPhase;
  logic [7:0] rspAddr;
  logic       ascIn = 1'b0;
  logic       prioIn = 1'b1;
  logic       stbDone = 1'b0;
  logic       edIn = 1'b0;
  logic       esIn = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  svc_seq_top #(.ADDR_W(8), .MAX_BYTES(4), .DEV_ADDR(ADDR)) u_dut (
    .clk(clk), .rstN(rstN), .svcWant(svcWant), .svcKind(svcKind), .svcLen(svcLen),
    .callOut(callOut), .ascIn(ascIn), .prioIn(prioIn), .prioOut(prioOut),
    .rspAck(rspAck), .rspAddr(rspAddr), .reqStrobe(reqStrobe), .dorOut(dorOut),
    .iorOut(iorOut), .stbDone(stbDone), .edIn(edIn), .esIn(esIn), .edOut(edOut),
    .termPhase(termPhase)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected end-data for a byte, from R7/R8
  function automatic bit expEd(input logic [1:0] kind, input int len, input int idx, input bit term);
    if (term) return 1'b0;
    return kind[1] || (idx == len);
  endfunction

  // expected request code, from R6
  function automatic int expCode(input logic [1:0] kind, input bit first, input bit term);
    return (first && !term) ? int'(kind) : 0;
  endfunction

  // mode 0: random end flags; mode 1: no end-service until the terminal subcycle
  task automatic runCycle(input logic [1:0] kind, input int len, input int mode);
    int idx = 0;
    int nTerm = 0;
    bit term = 1'b0;
    bit first = 1'b1;
    bit es, edi, ed;
    @(negedge clk);
    chk("R3", "prioOut idle", int'(prioOut), int'(prioIn));
    svcWant = 1'b1; svcKind = kind; svcLen = 2'(len);
    @(negedge clk);
    svcWant = 1'b0; svcKind = 2'($urandom); svcLen = 2'($urandom);
    chk("R2", "callOut after want", int'(callOut), 1);
    chk("R3", "prioOut while calling", int'(prioOut), 0);
    // grant attempt with priority blocked above
    ascIn = 1'b1; prioIn = 1'b0;
    @(negedge clk);
    chk("R4", "no ack without priority", int'(rspAck), 0);
    chk("R2", "still calling", int'(callOut), 1);
    prioIn = 1'b1;
    @(negedge clk);
    ascIn = 1'b0;
    chk("R4", "ack on grant", int'(rspAck), 1);
    chk("R4", "address on grant", int'(rspAddr), int'(ADDR));
    chk("R2", "call dropped", int'(callOut), 0);
    chk("R5", "no strobe during ack", int'(reqStrobe), 0);
    @(negedge clk);
    chk("R4", "ack single cycle", int'(rspAck), 0);
    chk("R4", "address released", int'(rspAddr), 0);
    forever begin
      chk("R5", "strobe up", int'(reqStrobe), 1);
      chk("R6", "request code", int'({dorOut, iorOut}), expCode(kind, first, term));
      chk("R7", "end-data", int'(edOut), int'(expEd(kind, len, idx, term)));
      chk("R8", "term phase", int'(termPhase), int'(term));
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        chk("R5", "strobe held", int'(reqStrobe), 1);
        chk("R7", "end-data held", int'(edOut), int'(expEd(kind, len, idx, term)));
      end
      if (mode == 1) begin
        es  = term;
        edi = 1'b0;
      end else begin
        es  = ($urandom % 4 == 0) || (nTerm >= 2);
        edi = !term && ($urandom % 5 == 0);
      end
      ed = expEd(kind, len, idx, term) || edi;
      stbDone = 1'b1; esIn = es; edIn = edi;
      @(negedge clk);
      stbDone = 1'b0; esIn = 1'b0; edIn = 1'b0;
      first = 1'b0;
      if (es) begin
        chk(term ? "R10" : "R9", "disconnect", int'(reqStrobe), 0);
        chk("R9", "no call after disconnect", int'(callOut), 0);
        break;
      end
      if (term) begin
        nTerm++;
        chk("R10", "repeat terminal", int'(termPhase), 1);
      end else if (ed) begin
        term = 1'b1;
        chk("R9", "terminal after end-data", int'(termPhase), 1);
      end else begin
        idx++;
        chk("R9", "next data strobe", int'(termPhase), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset callOut", int'(callOut), 0);
    chk("R1", "reset rspAck", int'(rspAck), 0);
    chk("R1", "reset reqStrobe", int'(reqStrobe), 0);
    chk("R1", "reset edOut", int'(edOut), 0);
    chk("R1", "reset code", int'({dorOut, iorOut}), 0);
    chk("R1", "reset prioOut", int'(prioOut), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2", "idle no call", int'(callOut), 0);
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin
      runCycle(2'(k), 3, 1);
      runCycle(2'(k), 0, 1);
    end
    for (int n = 0; n < 60; n++)
      runCycle(2'($urandom), int'($urandom % 4), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule